// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital timing and control logic that sits next to a successive-approximation converter. A CPU start write arms a conversion; the block then counts prescaled ADC clock periods and issues a one-cycle sample-and-hold strobe and a one-cycle completion strobe at exact half-period positions. The conversion length depends on whether this is the first conversion since enable, whether the applied input is differential, and on the phase of an internal clock that runs at half the ADC clock rate. A free-running mode restarts a new conversion on the edge where the previous one completes.

The CPU writes channel, differential flag and reference into a shadow copy. The applied copy that drives the analog mux follows the shadow while no conversion runs. It is frozen while a conversion runs and reopens for the final ADC clock period. A settling counter restarts whenever the applied reference, or a differential selection, changes. Every completed result carries a flag that marks it as taken inside the settling window. The result value itself comes from a stub input.

The ADC clock is not a separate clock domain. The prescaler pulses `half_en` once per half ADC period in the system clock domain. The block keeps its own ADC clock level, which is low after reset and toggles on each pulse, so every other pulse (the first, third, ...) is a rising ADC edge. The half-rate phase is low after reset and toggles on each rising ADC edge. The control path is a three-state machine:
- `ST_IDLE` goes to `ST_ARMED` on a start write while enabled.
- `ST_ARMED` goes to `ST_CONV` on the next rising ADC edge.
- `ST_CONV` goes back to `ST_CONV` with its counter restarted on a completion in free-running mode.
- `ST_CONV` goes to `ST_IDLE` on a completion otherwise.
- Every state goes to `ST_IDLE` when the enable is low.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy`, `done_flag`, `sh_strobe`, `done_strobe`, `result`, `result_unsettled` and the applied selection are all zero.
- R2: A conversion begins on the first rising ADC edge strictly after the system clock edge that samples `start_wr`. `busy` is 1 from the cycle after that edge and falls together with the completion strobe. Edge positions below are counted in `half_en` pulses from that start edge.
- R3: The first conversion after `adc_en` rises, or after reset, lasts 25 ADC periods (completion at half-step 50), with sample-and-hold at 14.5 periods (half-step 29).
- R4: A later single-ended conversion lasts 13 periods (completion at half-step 26), with sample-and-hold at half-step 3.
- R5: A user-started differential conversion lasts 13 periods with sample-and-hold at half-step 3 if the half-rate phase is low at its start edge. If the phase is high, it lasts 14 periods (half-step 28) with sample-and-hold at half-step 5.
- R6: With `free_run` high at a completion, the next conversion starts on that same edge without a new write. Such an automatic differential conversion lasts 14 periods with sample-and-hold at half-step 5. When `free_run` is low at a completion, the block returns to idle.
- R7: A start write while a conversion is armed or running is ignored: the counter does not restart and no extra conversion follows.
- R8: While no conversion runs, the applied selection takes the shadow value one system clock after it is written. From the start edge on, the applied selection is frozen.
- R9: The applied selection follows the shadow again from the start of the final ADC period. A selection written mid-conversion is therefore applied before `done_flag` rises.
- R10: `done_flag` is set with the completion strobe and stays set until a `flag_clr_wr` pulse. If a set and a clear land on the same edge, the set wins.
- R11: `result` captures `res_in` on the completion edge and holds it until the next completion.
- R12: A change of the applied reference, or of the applied channel or differential flag while the new selection is differential, restarts a settling window. The window lasts `ceil(ADC_CLK_KHZ*SETTLE_US/1000)` ADC periods (25 by default). `result_unsettled` is 1 for a result completed inside it. A single-ended channel change does not restart it.
- R13: Dropping `adc_en` aborts any conversion without a completion, returns to idle, and makes the next conversion a first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | One pulse per half ADC clock period |
| adc_en | input | 1 | Converter enable |
| free_run | input | 1 | Restart automatically after each completion |
| start_wr | input | 1 | CPU write of a one to the start bit |
| flag_clr_wr | input | 1 | CPU write of a one to clear the completion flag |
| sel_wr | input | 1 | CPU write of the selection shadow |
| sel_chan_in | input | CHAN_W | Channel number to write |
| sel_diff_in | input | 1 | 1 selects a differential input |
| sel_ref_in | input | REF_W | Reference selection to write |
| res_in | input | RES_W | Conversion value from the analog stub |
| busy | output | 1 | Start bit read-back, 1 while armed or converting |
| sh_strobe | output | 1 | One-cycle sample-and-hold strobe |
| done_strobe | output | 1 | One-cycle completion strobe |
| done_flag | output | 1 | Sticky completion flag |
| result | output | RES_W | Last captured conversion value |
| result_unsettled | output | 1 | Last result fell inside the settling window |
| app_chan | output | CHAN_W | Applied channel |
| app_diff | output | 1 | Applied differential flag |
| app_ref | output | REF_W | Applied reference |

## Verification
The hardest case to reach from the ports is a user-started differential conversion that begins while the half-rate phase is high. That phase is not visible at the ports, and it depends on how many rising ADC edges have passed since reset. The bench keeps `half_en` high every cycle and counts edges from reset release, so it can predict the phase at every candidate start edge. It then delays each start write until the predicted phase matches the one a table vector asks for. The same edge count is used to place a selection write in mid-conversion and to sample the applied selection on both sides of the final-period reopening, and to land a flag clear exactly on a completion edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Conversion lengths in ADC clock periods
    localparam int FIRST_CYC   = 25;
    localparam int SHORT_CYC   = 13;
    localparam int LONG_CYC    = 14;
    // Sample-and-hold positions in half ADC periods from the start edge
    localparam int FIRST_SH_HS = 29;
    localparam int SHORT_SH_HS = 3;
    localparam int LONG_SH_HS  = 5;
    // Half-step counter width covers the longest conversion
    localparam int HCNT_W      = $clog2(2 * FIRST_CYC + 1);

    typedef logic [HCNT_W-1:0] hcnt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_FIRST = 2'd0,
        KIND_SHORT = 2'd1,
        KIND_LONG  = 2'd2
    } conv_kind_e;

    function automatic hcnt_t kind_len_hs(input conv_kind_e k);
        case (k)
            KIND_FIRST: return hcnt_t'(2 * FIRST_CYC);
            KIND_LONG:  return hcnt_t'(2 * LONG_CYC);
            default:    return hcnt_t'(2 * SHORT_CYC);
        endcase
    endfunction

    function automatic hcnt_t kind_sh_hs(input conv_kind_e k);
        case (k)
            KIND_FIRST: return hcnt_t'(FIRST_SH_HS);
            KIND_LONG:  return hcnt_t'(LONG_SH_HS);
            default:    return hcnt_t'(SHORT_SH_HS);
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_phase.sv
module adc_clk_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    output logic rise,
    output logic div2
);
    logic lvl;

    assign rise = half_en & ~lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl  <= 1'b0;
            div2 <= 1'b0;
        end else begin
            if (half_en) lvl  <= ~lvl;
            if (rise)    div2 <= ~div2;
        end
    end

    // R2: two rising ADC edges are never adjacent system cycles
    p_rise_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R5: the half-rate phase only moves on a rising ADC edge
    p_div2_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 != $past(div2)) |-> $past(rise));

endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
    parameter int CHAN_W     = 5,
    parameter int REF_W      = 2,
    parameter int SETTLE_CYC = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              diff_in,
    input  logic [REF_W-1:0]  ref_in,
    input  logic              lock,
    input  logic              rise,
    output logic              shd_diff,
    output logic [CHAN_W-1:0] app_chan,
    output logic              app_diff,
    output logic [REF_W-1:0]  app_ref,
    output logic              unsettled
);
    localparam int SC_W = $clog2(SETTLE_CYC + 1);

    logic [CHAN_W-1:0] shd_chan;
    logic [REF_W-1:0]  shd_ref;
    logic [SC_W-1:0]   settle_cnt;
    logic              reload;

    // A copy step that moves the reference or lands on a new differential input
    always_comb begin
        reload = !lock && ((shd_ref != app_ref) ||
                 (shd_diff && ((shd_chan != app_chan) || !app_diff)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_chan <= '0;
            shd_diff <= 1'b0;
            shd_ref  <= '0;
        end else if (sel_wr) begin
            shd_chan <= chan_in;
            shd_diff <= diff_in;
            shd_ref  <= ref_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            app_chan <= '0;
            app_diff <= 1'b0;
            app_ref  <= '0;
        end else if (!lock) begin
            app_chan <= shd_chan;
            app_diff <= shd_diff;
            app_ref  <= shd_ref;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt <= '0;
        end else if (reload) begin
            settle_cnt <= SC_W'(SETTLE_CYC);
        end else if (rise && (settle_cnt != '0)) begin
            settle_cnt <= settle_cnt - 1'b1;
        end
    end

    assign unsettled = (settle_cnt != '0);

    // R8: applied selection frozen while locked
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(app_chan) && $stable(app_diff) && $stable(app_ref)));

    // R8: applied selection takes the shadow when open
    p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> (app_chan == $past(shd_chan) && app_ref == $past(shd_ref)));

    // R12: a reference change always restarts the window
    p_ref_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (app_ref != $past(app_ref)) |-> (settle_cnt == SC_W'(SETTLE_CYC)));

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    input  logic rise,
    input  logic div2,
    input  logic adc_en,
    input  logic free_run,
    input  logic start_wr,
    input  logic next_diff,
    output logic busy,
    output logic lock,
    output logic sh_evt,
    output logic done_evt,
    output logic sh_strobe,
    output logic done_strobe
);
    seq_state_e state, state_nx;
    conv_kind_e kind, kind_nx, user_kind, auto_kind;
    hcnt_t      hcnt, hcnt_nx, hnext, len_hs, sh_hs;
    logic       first_pend, first_nx, conv_tick;

    always_comb begin
        len_hs    = kind_len_hs(kind);
        sh_hs     = kind_sh_hs(kind);
        hnext     = hcnt + 1'b1;
        conv_tick = (state == ST_CONV) && half_en;
        sh_evt    = adc_en && conv_tick && (hnext == sh_hs);
        done_evt  = adc_en && conv_tick && (hnext == len_hs);
        user_kind = first_pend ? KIND_FIRST :
                    ((next_diff && div2) ? KIND_LONG : KIND_SHORT);
        auto_kind = next_diff ? KIND_LONG : KIND_SHORT;
    end

    always_comb begin
        state_nx = state;
        kind_nx  = kind;
        hcnt_nx  = hcnt;
        first_nx = first_pend;
        if (!adc_en) begin
            state_nx = ST_IDLE;
            hcnt_nx  = '0;
            first_nx = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_wr) state_nx = ST_ARMED;
                end
                ST_ARMED: begin
                    if (rise) begin
                        state_nx = ST_CONV;
                        hcnt_nx  = '0;
                        kind_nx  = user_kind;
                        first_nx = 1'b0;
                    end
                end
                ST_CONV: begin
                    if (done_evt) begin
                        hcnt_nx = '0;
                        if (free_run) kind_nx  = auto_kind;
                        else          state_nx = ST_IDLE;
                    end else if (half_en) begin
                        hcnt_nx = hnext;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= KIND_FIRST;
            hcnt       <= '0;
            first_pend <= 1'b1;
        end else begin
            state      <= state_nx;
            kind       <= kind_nx;
            hcnt       <= hcnt_nx;
            first_pend <= first_nx;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_strobe   <= 1'b0;
            done_strobe <= 1'b0;
        end else begin
            sh_strobe   <= sh_evt;
            done_strobe <= done_evt;
        end
    end

    assign busy = (state != ST_IDLE);
    assign lock = (state == ST_CONV) && (hcnt < (len_hs - hcnt_t'(2)));

    // R2: busy only rises after a start write
    p_busy_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_wr));

    // R4: sample strobe only inside a conversion
    p_sh_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |-> busy);

    // R6: sample and completion never coincide
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_strobe && done_strobe));

    // R7: a start write in mid-conversion does not restart the count
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && start_wr && adc_en && !done_evt)
        |=> (state == ST_CONV && hcnt >= $past(hcnt)));

    // R9: selection is open again by the completion edge
    p_open_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> !lock);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W      = 5,
    parameter int REF_W       = 2,
    parameter int RES_W       = 10,
    parameter int ADC_CLK_KHZ = 200,
    parameter int SETTLE_US   = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_en,
    input  logic              adc_en,
    input  logic              free_run,
    input  logic              start_wr,
    input  logic              flag_clr_wr,
    input  logic              sel_wr,
    input  logic [CHAN_W-1:0] sel_chan_in,
    input  logic              sel_diff_in,
    input  logic [REF_W-1:0]  sel_ref_in,
    input  logic [RES_W-1:0]  res_in,
    output logic              busy,
    output logic              sh_strobe,
    output logic              done_strobe,
    output logic              done_flag,
    output logic [RES_W-1:0]  result,
    output logic              result_unsettled,
    output logic [CHAN_W-1:0] app_chan,
    output logic              app_diff,
    output logic [REF_W-1:0]  app_ref
);
    localparam int SETTLE_CYC = (ADC_CLK_KHZ * SETTLE_US + 999) / 1000;

    logic rise, div2, lock, shd_diff, unsettled, sh_evt, done_evt;

    adc_clk_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_en (half_en),
        .rise    (rise),
        .div2    (div2)
    );

    adc_sel_shadow #(
        .CHAN_W     (CHAN_W),
        .REF_W      (REF_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .chan_in   (sel_chan_in),
        .diff_in   (sel_diff_in),
        .ref_in    (sel_ref_in),
        .lock      (lock),
        .rise      (rise),
        .shd_diff  (shd_diff),
        .app_chan  (app_chan),
        .app_diff  (app_diff),
        .app_ref   (app_ref),
        .unsettled (unsettled)
    );

    adc_conv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_en     (half_en),
        .rise        (rise),
        .div2        (div2),
        .adc_en      (adc_en),
        .free_run    (free_run),
        .start_wr    (start_wr),
        .next_diff   (shd_diff),
        .busy        (busy),
        .lock        (lock),
        .sh_evt      (sh_evt),
        .done_evt    (done_evt),
        .sh_strobe   (sh_strobe),
        .done_strobe (done_strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag        <= 1'b0;
            result           <= '0;
            result_unsettled <= 1'b0;
        end else begin
            if (done_evt) begin
                done_flag        <= 1'b1;
                result           <= res_in;
                result_unsettled <= unsettled;
            end else if (flag_clr_wr) begin
                done_flag <= 1'b0;
            end
        end
    end

    // R10: flag stays set until cleared
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr_wr) |=> done_flag);

    // R10: completion strobe always shows with the flag
    p_flag_with_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_strobe |-> done_flag);

    // R11: result moves only with a completion
    p_result_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> done_strobe);

endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
    localparam int CHW = 5;
    localparam int RW  = 10;

    // {differential, wanted phase (-1 any), completion half-step, sample half-step}
    localparam int VEC [6][4] = '{
        '{0, -1, 50, 29},
        '{0,  0, 26,  3},
        '{0,  1, 26,  3},
        '{1,  0, 26,  3},
        '{1,  1, 28,  5},
        '{1,  0, 26,  3}
    };

    logic clk = 1'b0, rst_n = 1'b0, half_en = 1'b1, adc_en = 1'b0, free_run = 1'b0;
    logic start_wr = 1'b0, flag_clr_wr = 1'b0, sel_wr = 1'b0, sel_diff_in = 1'b0;
    logic [CHW-1:0] sel_chan_in = '0;
    logic [1:0]     sel_ref_in  = '0;
    logic [RW-1:0]  res_in      = '0;
    logic busy, sh_strobe, done_strobe, done_flag, result_unsettled, app_diff;
    logic [RW-1:0]  result;
    logic [CHW-1:0] app_chan;
    logic [1:0]     app_ref;

    adc_conv_seq dut (
        .clk(clk), .rst_n(rst_n), .half_en(half_en), .adc_en(adc_en),
        .free_run(free_run), .start_wr(start_wr), .flag_clr_wr(flag_clr_wr),
        .sel_wr(sel_wr), .sel_chan_in(sel_chan_in), .sel_diff_in(sel_diff_in),
        .sel_ref_in(sel_ref_in), .res_in(res_in), .busy(busy),
        .sh_strobe(sh_strobe), .done_strobe(done_strobe), .done_flag(done_flag),
        .result(result), .result_unsettled(result_unsettled),
        .app_chan(app_chan), .app_diff(app_diff), .app_ref(app_ref)
    );

    always #4 clk = ~clk;

    // After edge n (counted from reset release) ec equals n+1
    int ec = 0;
    always @(posedge clk) ec <= rst_n ? ec + 1 : 0;

    int sh_count = 0, done_count = 0;
    int sh_hist [64];
    int done_hist [64];
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (sh_strobe)   begin sh_hist[sh_count % 64] = ec - 1; sh_count++; end
            if (done_strobe) begin done_hist[done_count % 64] = ec - 1; done_count++; end
        end
    end

    int n_tests = 0, n_fail = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_sel(input logic d, input int ch, input int rf);
        @(negedge clk);
        sel_diff_in = d; sel_chan_in = ch[CHW-1:0]; sel_ref_in = rf[1:0]; sel_wr = 1'b1;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr_wr = 1'b1;
        @(negedge clk); flag_clr_wr = 1'b0;
    endtask

    task automatic start_at(input int want, output int es);
        int e0;
        while (1) begin
            @(negedge clk);
            e0 = ec;
            es = (e0 % 2 == 0) ? e0 + 2 : e0 + 1;
            if (want < 0 || ((es / 2) % 2) == want) break;
        end
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        while (done_count == prev) @(negedge clk);
    endtask

    task automatic wait_after(input int e);
        while (ec < e + 1) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int es, d0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done_flag", int'(done_flag), 0);
        check("R1", "strobes", int'(sh_strobe | done_strobe), 0);
        check("R1", "app_chan", int'(app_chan), 0);
        check("R1", "result", int'(result), 0);
        check("R1", "unsettled", int'(result_unsettled), 0);
        adc_en = 1'b1;

        // Table of conversion kinds
        for (int i = 0; i < 6; i++) begin
            string tag;
            tag = (i == 0) ? "R3" : ((VEC[i][0] != 0) ? "R5" : "R4");
            write_sel(VEC[i][0] != 0, i + 1, 0);
            res_in = RW'(100 + 37 * i);
            clear_flag();
            d0 = done_count; s0 = sh_count;
            start_at(VEC[i][1], es);
            wait_done(d0);
            check(tag, "sample offset", sh_hist[s0 % 64] - es, VEC[i][3]);
            check(tag, "completion offset", done_hist[d0 % 64] - es, VEC[i][2]);
            check("R10", "flag set", int'(done_flag), 1);
            check("R11", "result", int'(result), 100 + 37 * i);
            check("R2", "busy cleared", int'(busy), 0);
        end

        // R2 busy right after write
        clear_flag();
        d0 = done_count;
        start_at(-1, es);
        check("R2", "busy after write", int'(busy), 1);
        wait_done(d0);

        // R7 start while converting ignored
        write_sel(0, 2, 0);
        d0 = done_count;
        start_at(0, es);
        wait_after(es + 8);
        start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
        wait_done(d0);
        check("R7", "completion unchanged", done_hist[d0 % 64] - es, 26);
        repeat (60) @(negedge clk);
        check("R7", "no extra conversion", done_count, d0 + 1);
        check("R7", "idle", int'(busy), 0);

        // R6 free-running differential
        write_sel(1, 7, 0);
        free_run = 1'b1;
        d0 = done_count; s0 = sh_count;
        start_at(0, es);
        wait_done(d0);
        wait_done(d0 + 1);
        free_run = 1'b0;
        wait_done(d0 + 2);
        check("R6", "first user length", done_hist[d0 % 64] - es, 26);
        check("R6", "auto length 2", done_hist[(d0 + 1) % 64] - done_hist[d0 % 64], 28);
        check("R6", "auto length 3", done_hist[(d0 + 2) % 64] - done_hist[(d0 + 1) % 64], 28);
        check("R6", "auto sample", sh_hist[(s0 + 1) % 64] - done_hist[d0 % 64], 5);
        repeat (60) @(negedge clk);
        check("R6", "stops when off", done_count, d0 + 3);
        check("R6", "idle after stop", int'(busy), 0);

        // R8 / R9 shadow locking
        write_sel(0, 1, 0);
        @(negedge clk);
        check("R8", "idle follows shadow", int'(app_chan), 1);
        clear_flag();
        start_at(0, es);
        wait_after(es + 6);
        write_sel(0, 9, 0);
        wait_after(es + 24);
        check("R8", "frozen mid conversion", int'(app_chan), 1);
        wait_after(es + 25);
        check("R9", "reopened last period", int'(app_chan), 9);
        check("R9", "flag still clear", int'(done_flag), 0);

        // R10 sticky and set priority
        repeat (10) @(negedge clk);
        check("R10", "sticky", int'(done_flag), 1);
        clear_flag();
        check("R10", "cleared", int'(done_flag), 0);
        start_at(0, es);
        wait_after(es + 25);
        flag_clr_wr = 1'b1; @(negedge clk); flag_clr_wr = 1'b0;
        check("R10", "set wins over clear", int'(done_flag), 1);

        // R12 settling window
        repeat (60) @(negedge clk);
        write_sel(0, 9, 1);
        d0 = done_count; start_at(-1, es); wait_done(d0);
        check("R12", "ref change unsettled", int'(result_unsettled), 1);
        repeat (60) @(negedge clk);
        d0 = done_count; start_at(-1, es); wait_done(d0);
        check("R12", "settled later", int'(result_unsettled), 0);
        write_sel(0, 4, 1);
        d0 = done_count; start_at(-1, es); wait_done(d0);
        check("R12", "single-ended change settled", int'(result_unsettled), 0);
        write_sel(1, 4, 1);
        d0 = done_count; start_at(-1, es); wait_done(d0);
        check("R12", "differential change unsettled", int'(result_unsettled), 1);

        // R13 abort by enable
        clear_flag();
        d0 = done_count;
        start_at(-1, es);
        wait_after(es + 10);
        adc_en = 1'b0;
        @(negedge clk);
        check("R13", "abort idle", int'(busy), 0);
        adc_en = 1'b1;
        repeat (40) @(negedge clk);
        check("R13", "no completion", done_count, d0);
        check("R13", "flag clear", int'(done_flag), 0);
        s0 = sh_count;
        start_at(0, es);
        wait_done(d0);
        check("R13", "first length again", done_hist[d0 % 64] - es, 50);
        check("R3", "first sample again", sh_hist[s0 % 64] - es, 29);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule